// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns one asynchronous serial line into 8-bit characters. A one-cycle enable that pulses sixteen times per bit period paces it. The line passes through a synchronizer first. The receiver then waits for a falling edge and checks that the line is still low halfway through the start bit. After that it takes one sample in the middle of each later bit: eight data bits with the least significant first, then a parity bit if one is configured, then the stop bit. The finished character goes into a one-entry receive buffer, and `rx_irq` pulses for one clock.

Each completed frame reloads three per-frame status flags: parity error, framing error and break. An all-zero frame is a break, and after one the receiver waits for the line to go high again before it looks for a new start bit. A sticky overrun flag records that a character arrived while the buffer still held an unread one; the new character replaces the old one. A summary error output combines overrun, parity and framing.

The buffer side is a valid/ready stream. `rx_valid` is high while the buffer holds a character, and a read takes place on any clock where `rx_valid` and `rx_ready` are both high. The serial line cannot be stalled, so back-pressure has no effect on reception. A consumer that does not read in time loses the older character and sees the overrun flag.

Top module: `serial_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_irq`, `ovr_flag`, `par_flag`, `frm_flag`, `brk_flag` and `err_flag` are all 0.
- R2: A frame is a low start bit, 8 data bits with the least significant first, an optional parity bit and a stop bit. Each bit lasts 16 `os_tick` pulses. When a frame completes, `rx_data` holds the character, `rx_valid` goes to 1 and `rx_irq` is high for exactly one clock.
- R3: A low that is no longer low at the 8th tick after it was detected is a glitch. The receiver returns to idle without producing a frame and without changing any output.
- R4: `par_mode` is encoded as 00 none (no parity bit in the frame), 01 odd, 10 even, 11 fixed. In odd mode `par_flag` is set when the number of 1s in the data bits plus the parity bit is even. In even mode it is set when that number is odd. In none mode it is 0.
- R5: In fixed mode (11), the parity bit must equal `par_fixed_val`. If it differs, `par_flag` is set.
- R6: `frm_flag` is set when the stop bit is sampled low.
- R7: `brk_flag` is set when every sampled bit from the start bit through the stop bit is 0. After such a frame, no new start bit is recognised until the line has been high.
- R8: If a frame completes while `rx_valid` is 1 and no read happens on that clock, `ovr_flag` is set and `rx_data` takes the new character. `ovr_flag` stays set through later frames until a read.
- R9: A read clears `rx_valid` and `ovr_flag` on the next clock, unless a new frame completes on that same clock.
- R10: `err_flag` is 1 exactly when at least one of `ovr_flag`, `par_flag` and `frm_flag` is 1.
- R11: `par_flag`, `frm_flag` and `brk_flag` change only on the clock where `rx_irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idles high |
| par_mode | input | 2 | Parity mode: 00 none, 01 odd, 10 even, 11 fixed |
| par_fixed_val | input | 1 | Expected parity bit value in fixed mode |
| rx_data | output | 8 | Receive buffer contents |
| rx_valid | output | 1 | Receive buffer holds an unread character |
| rx_ready | input | 1 | Consumer accepts the character (read when `rx_valid` is high) |
| rx_irq | output | 1 | One-clock pulse when a frame completes |
| ovr_flag | output | 1 | Sticky overrun flag |
| par_flag | output | 1 | Parity error of the last frame |
| frm_flag | output | 1 | Framing error of the last frame |
| brk_flag | output | 1 | Break condition of the last frame |
| err_flag | output | 1 | OR of overrun, parity and framing flags |

## Verification
The stop bit is sampled at its middle, delayed by the two synchronizer flops and the tick phase. The buffer, all flags and `rx_irq` change together one clock after that sample. The scoreboard therefore does not count cycles from the stimulus. It waits for `rx_irq` and compares every output on the falling edge of that same cycle. A read made by raising `rx_ready` is checked at the falling edge one clock later. The glitch and break-hold cases compare the interrupt count and the outputs after a fixed idle window that is longer than a complete frame.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_t;

  localparam logic [1:0] PM_NONE  = 2'b00;
  localparam logic [1:0] PM_ODD   = 2'b01;
  localparam logic [1:0] PM_EVEN  = 2'b10;
  localparam logic [1:0] PM_FIXED = 2'b11;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES == 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= 1'b1;
        else        q <= din;
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      assign dout = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxs,
  input  logic              par_en,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              pbit,
  output logic              stop_bit,
  output logic              all_zero
);
  localparam int CW   = $clog2(OS_RATE);
  localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int MID  = OS_RATE / 2 - 1;
  localparam int LAST = OS_RATE - 1;

  rx_state_t       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   idx;
  logic            zacc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      zacc     <= 1'b0;
      done     <= 1'b0;
      data     <= '0;
      pbit     <= 1'b0;
      stop_bit <= 1'b1;
      all_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: if (!rxs) begin
            st  <= ST_START;
            cnt <= '0;
          end
          ST_START: begin
            if (cnt == CW'(MID)) begin
              cnt <= '0;
              if (rxs) st <= ST_IDLE;
              else begin
                st   <= ST_DATA;
                idx  <= '0;
                zacc <= 1'b1;
                pbit <= 1'b0;
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (cnt == CW'(LAST)) begin
              cnt  <= '0;
              data <= {rxs, data[DATA_W-1:1]};
              zacc <= zacc & ~rxs;
              if (idx == BW'(DATA_W - 1)) st <= par_en ? ST_PAR : ST_STOP;
              else idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (cnt == CW'(LAST)) begin
              cnt  <= '0;
              pbit <= rxs;
              zacc <= zacc & ~rxs;
              st   <= ST_STOP;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (cnt == CW'(LAST)) begin
              cnt      <= '0;
              done     <= 1'b1;
              stop_bit <= rxs;
              all_zero <= zacc & ~rxs;
              st       <= (zacc & ~rxs) ? ST_HOLD : ST_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          ST_HOLD: if (rxs) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_parity.sv
module rx_parity
  import rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        mode,
  input  logic              fixed_val,
  input  logic [DATA_W-1:0] data,
  input  logic              pbit,
  output logic              err
);
  logic odd_ones;
  assign odd_ones = ^{data, pbit};

  always_comb begin
    case (mode)
      PM_ODD:   err = ~odd_ones;
      PM_EVEN:  err = odd_ones;
      PM_FIXED: err = (pbit != fixed_val);
      default:  err = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_holdreg.sv
module rx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data_in,
  input  logic              perr,
  input  logic              stop_bit,
  input  logic              zero_frame,
  input  logic              ready,
  output logic [DATA_W-1:0] data_q,
  output logic              valid,
  output logic              irq,
  output logic              ovr,
  output logic              par,
  output logic              frm,
  output logic              brk,
  output logic              err
);
  logic rd;
  assign rd  = valid & ready;
  assign err = ovr | par | frm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      valid  <= 1'b0;
      irq    <= 1'b0;
      ovr    <= 1'b0;
      par    <= 1'b0;
      frm    <= 1'b0;
      brk    <= 1'b0;
    end else begin
      irq <= done;
      if (done) begin
        data_q <= data_in;
        valid  <= 1'b1;
        par    <= perr;
        frm    <= ~stop_bit;
        brk    <= zero_frame;
        if (rd)         ovr <= 1'b0;
        else if (valid) ovr <= 1'b1;
      end else if (rd) begin
        valid <= 1'b0;
        ovr   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic [1:0]        par_mode,
  input  logic              par_fixed_val,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_irq,
  output logic              ovr_flag,
  output logic              par_flag,
  output logic              frm_flag,
  output logic              brk_flag,
  output logic              err_flag
);
  logic              rxs;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_pbit;
  logic              frame_stop;
  logic              frame_zero;
  logic              frame_perr;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
  );

  rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxs(rxs),
    .par_en(par_mode != PM_NONE),
    .done(frame_done), .data(frame_data), .pbit(frame_pbit),
    .stop_bit(frame_stop), .all_zero(frame_zero)
  );

  rx_parity #(.DATA_W(DATA_W)) u_par (
    .mode(par_mode), .fixed_val(par_fixed_val), .data(frame_data),
    .pbit(frame_pbit), .err(frame_perr)
  );

  rx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .data_in(frame_data),
    .perr(frame_perr), .stop_bit(frame_stop), .zero_frame(frame_zero),
    .ready(rx_ready), .data_q(rx_data), .valid(rx_valid), .irq(rx_irq),
    .ovr(ovr_flag), .par(par_flag), .frm(frm_flag), .brk(brk_flag),
    .err(err_flag)
  );
endmodule

// File: rtl/rx_sva.sv
module rx_sva (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic valid,
  input logic ready,
  input logic ovr,
  input logic par,
  input logic frm,
  input logic brk,
  input logic s_done
);
  // R2
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R2
  irq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> valid);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !s_done) |=> (!valid && !ovr));

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable({par, frm, brk}));

  // R8
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> irq);

  // R7
  brk_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> frm);
endmodule

bind serial_rx rx_sva u_sva (
  .clk(clk), .rst_n(rst_n), .irq(rx_irq), .valid(rx_valid),
  .ready(rx_ready), .ovr(ovr_flag), .par(par_flag), .frm(frm_flag),
  .brk(brk_flag), .s_done(frame_done)
);

// File: tb/sim_serial_rx.sv
`timescale 1ns/1ps
module sim_serial_rx;
  typedef struct {
    logic [7:0] d;
    bit         par;
    bit         frm;
    bit         brk;
    bit         ovr;
    bit         rd;
    string      ptag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] par_mode = 2'b00;
  logic       par_fixed_val = 1'b0;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_irq, ovr_flag, par_flag, frm_flag, brk_flag, err_flag;

  int   tests = 0;
  int   fails = 0;
  int   irq_seen = 0;
  bit   unread = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) os_tick <= rst_n ? ~os_tick : 1'b0;

  serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .par_mode(par_mode), .par_fixed_val(par_fixed_val), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_irq(rx_irq),
    .ovr_flag(ovr_flag), .par_flag(par_flag), .frm_flag(frm_flag),
    .brk_flag(brk_flag), .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic hold_ticks(input logic v, input int n);
    rxd = v;
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v,
                      input bit rd, input int extra_low);
    exp_t e;
    logic p;
    case (par_mode)
      2'b01:   p = ~^d;
      2'b10:   p = ^d;
      default: p = par_fixed_val;
    endcase
    if (bad_par) p = ~p;
    e.d    = d;
    e.par  = bad_par && (par_mode != 2'b00);
    e.frm  = !stop_v;
    e.brk  = (d == 8'h00) && !stop_v && (par_mode == 2'b00 || p == 1'b0);
    e.ovr  = unread;
    e.rd   = rd;
    e.ptag = (par_mode == 2'b11) ? "R5" : "R4";
    unread = !rd;
    q.push_back(e);
    hold_ticks(1'b0, 16);
    for (int i = 0; i < 8; i++) hold_ticks(d[i], 16);
    if (par_mode != 2'b00) hold_ticks(p, 16);
    if (stop_v) hold_ticks(1'b1, 16);
    else        hold_ticks(1'b0, 12 + extra_low);
    hold_ticks(1'b1, 40);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rx_irq) begin
        irq_seen++;
        if (q.size() == 0) begin
          chk(1'b0, "R2", "unexpected frame", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rx_data == e.d, "R2", "data", rx_data, e.d);
          chk(rx_valid, "R2", "valid", rx_valid, 1);
          chk(par_flag == e.par, e.ptag, "parity flag", par_flag, e.par);
          chk(frm_flag == e.frm, "R6", "framing flag", frm_flag, e.frm);
          chk(brk_flag == e.brk, "R7", "break flag", brk_flag, e.brk);
          chk(ovr_flag == e.ovr, "R8", "overrun flag", ovr_flag, e.ovr);
          chk(err_flag == (e.ovr | e.par | e.frm), "R10", "error summary",
              err_flag, e.ovr | e.par | e.frm);
          @(negedge clk);
          chk(!rx_irq, "R2", "irq one cycle", rx_irq, 0);
          if (e.rd) begin
            rx_ready = 1'b1;
            @(negedge clk);
            rx_ready = 1'b0;
            chk(!rx_valid && !ovr_flag, "R9", "read clears valid/ovr",
                {rx_valid, ovr_flag}, 0);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int snap;
    logic [7:0] d_snap;
    logic [3:0] f_snap;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({rx_valid, rx_irq, ovr_flag, par_flag, frm_flag, brk_flag, err_flag} == 7'b0,
        "R1", "reset outputs",
        {rx_valid, rx_irq, ovr_flag, par_flag, frm_flag, brk_flag, err_flag}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    par_mode = 2'b00;
    send(8'hA5, 0, 1, 1, 0);
    send(8'h3C, 0, 1, 1, 0);
    par_mode = 2'b01;
    send(8'h5A, 0, 1, 1, 0);
    send(8'h5B, 1, 1, 1, 0);
    par_mode = 2'b10;
    send(8'h81, 0, 1, 1, 0);
    send(8'h83, 1, 1, 1, 0);
    par_mode = 2'b11; par_fixed_val = 1'b0;
    send(8'h77, 0, 1, 1, 0);
    send(8'h77, 1, 1, 1, 0);
    par_fixed_val = 1'b1;
    send(8'h12, 0, 1, 1, 0);
    send(8'h12, 1, 1, 1, 0);
    par_mode = 2'b00;
    send(8'hF0, 0, 0, 1, 0);
    // R8 overrun chain
    send(8'h11, 0, 1, 0, 0);
    send(8'h22, 0, 1, 0, 0);
    send(8'h33, 0, 1, 1, 0);
    send(8'h44, 0, 1, 1, 0);

    // R3 glitch rejection
    snap = irq_seen; d_snap = rx_data;
    f_snap = {rx_valid, par_flag, frm_flag, brk_flag};
    hold_ticks(1'b0, 4);
    hold_ticks(1'b1, 200);
    chk(irq_seen == snap, "R3", "glitch produced frame", irq_seen, snap);
    chk(rx_data == d_snap && {rx_valid, par_flag, frm_flag, brk_flag} == f_snap,
        "R11", "outputs unchanged after glitch", {rx_data, rx_valid}, {d_snap, f_snap[3]});

    // R7 break and hold-low
    send(8'h00, 0, 0, 1, 480);
    snap = irq_seen;
    chk(snap > 0 && q.size() == 0, "R7", "break frame seen", q.size(), 0);
    send(8'h55, 0, 1, 1, 0);
    repeat (20) @(negedge clk);
    chk(irq_seen == snap + 1, "R7", "single frame after break", irq_seen, snap + 1);
    chk(q.size() == 0, "R2", "all frames received", q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule